// File: doc/BRIEF.md
# Multicart Bank-Switching Mapper

This block sits between an 8-bit console's CPU and PPU buses and the ROM and RAM chips of a multi-game cartridge. Software first writes a register index into a select latch. A later write to the upper half of the CPU space then loads one of four 8-bit banking registers. The registers are a character bank, an inner program bank, a mode register and an outer program bank. From them the block forms the program ROM address, the character memory address, a work-RAM enable and the nametable A10 select.

Program memory is handled as 16 KB pages. The outer register selects a region of the ROM, and the inner register selects a page or page pair inside that region. The game-size field in the mode register moves the boundary between the outer bits and the inner bits. In 32 KB mode both CPU halves follow the inner value together. In 16 KB mode one half is switchable and the other stays fixed at one end of the outer 32 KB block; the slot-select bit chooses which half is fixed.

All outputs are combinational functions of the registers and the current bus addresses. The register state changes only on a clock edge that sees the write strobe together with a matching address. The write-decode regions are modelled as an enumeration with four named values: `RGN_OTHER`, `RGN_SELECT`, `RGN_WRAM` and `RGN_BANK`. The nametable modes are also an enumeration: `NT_ONE_LO` and `NT_ONE_HI` (both single-screen, screen chosen by the mirroring bit), `NT_VERTICAL` and `NT_HORIZONTAL`. The block has no sequencing states. Every register changes directly from one captured write to the next.

Top module: `mcart_mapper`

## Requirements
- R1: A CPU write with address bits 15:12 equal to 0x5 loads the 2-bit register index as {data[7], data[0]}. Data bits 6:1 have no effect on it.
- R2: A CPU write with address bit 15 set stores the whole data byte into the register named by the index. Writes to any other address change no banking register. Register numbering: 0 character bank, 1 inner bank, 2 mode, 3 outer bank.
- R3: chr_addr equals {register 0 bits 1:0, ppu_addr[12:0]}.
- R4: The mirroring bit takes data[4] on a banking write to register 0 or 1. It takes data[0] on a write to register 2. A write to register 3 leaves it unchanged.
- R5: Mode bits 1:0 select the nametable mode. Values 0 and 1 give single-screen, with nt_a10 equal to the mirroring bit. Value 2 gives vertical mirroring (nt_a10 = ppu_addr[10]). Value 3 gives horizontal mirroring (nt_a10 = ppu_addr[11]).
- R6: The game size is mode bits 5:4. A game size of g gives an inner page mask of (2^(g+1))-1 (0x01, 0x03, 0x07, 0x0F). The outer mask is its complement within 9 bits (0x1FE, 0x1FC, 0x1F8, 0x1F0). The outer page base is {register 3, 0}.
- R7: With mode bit 3 clear (32 KB mode), the lower page is (base & outer mask) | ((2·inner) & inner mask). The upper page is the same with bit 0 of the doubled inner value set.
- R8: With mode bit 3 set and mode bit 2 (slot select) clear, the lower page is fixed at base & 0x1FE. The upper page is (base & outer mask) | (inner & inner mask). The inner value is register 1 bits 3:0.
- R9: With mode bits 3 and 2 both set, the lower page is the switchable page from R8. The upper page is fixed at (base & 0x1FE) | 1.
- R10: prg_addr equals {page, cpu_addr[13:0]}. cpu_addr[14] = 0 selects the lower page and 1 selects the upper page.
- R11: Reset clears the index, all four registers and the mirroring bit. After reset the lower page is 0, the upper page is 1 and the nametable is single-screen lower.
- R12: wram_en is 1 exactly when cpu_addr lies in 0x6000–0x7FFF.
- R13: A cycle with cpu_wr low changes no state, whatever the addresses and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, active high |
| ppu_addr | input | 14 | PPU address |
| prg_addr | output | 23 | Program ROM address (9-bit page, 14-bit offset) |
| chr_addr | output | 15 | Character memory address (2-bit bank, 13-bit offset) |
| wram_en | output | 1 | Work-RAM window enable |
| nt_a10 | output | 1 | Nametable A10 select |

## Verification
The bench builds the block with its default parameters: an 8-bit outer register, a 4-bit inner field and a 2-bit character bank. This makes all 512 program pages reachable, including the top page bit that only register 3 bit 7 can set, and all four character banks. Random select, banking and stray writes are mixed with random CPU and PPU probe addresses. This brings every game-size mask, both slot choices and all four nametable modes within reach. Directed cases cover the reset mapping, the index encodings, the mirroring-bit rules and idle cycles that carry a banking address.

// File: rtl/mcm_pkg.sv
package mcm_pkg;

    localparam int DATA_W    = 8;
    localparam int REG_COUNT = 4;
    localparam int REG_IDX_W = $clog2(REG_COUNT);

    // Register numbering (decoded by the index latch)
    localparam int IDX_CHR   = 0;
    localparam int IDX_INNER = 1;
    localparam int IDX_MODE  = 2;
    localparam int IDX_OUTER = 3;

    // Mode register field positions
    localparam int MODE_NT_LSB   = 0;
    localparam int MODE_SLOT_BIT = 2;
    localparam int MODE_HALF_BIT = 3;
    localparam int MODE_GS_LSB   = 4;

    typedef enum logic [1:0] {
        RGN_OTHER  = 2'd0,
        RGN_SELECT = 2'd1,
        RGN_WRAM   = 2'd2,
        RGN_BANK   = 2'd3
    } cpu_region_e;

    typedef enum logic [1:0] {
        NT_ONE_LO     = 2'd0,
        NT_ONE_HI     = 2'd1,
        NT_VERTICAL   = 2'd2,
        NT_HORIZONTAL = 2'd3
    } nt_mode_e;

    // Region from the top nibble of the CPU address
    function automatic cpu_region_e decode_region(input logic [3:0] nib);
        cpu_region_e r;
        if (nib[3])
            r = RGN_BANK;
        else if (nib == 4'h5)
            r = RGN_SELECT;
        else if (nib[3:1] == 3'b011)
            r = RGN_WRAM;
        else
            r = RGN_OTHER;
        return r;
    endfunction

endpackage

// File: rtl/mcm_regfile.sv
module mcm_regfile
    import mcm_pkg::*;
(
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [3:0]                            cpu_nib,
    input  logic [DATA_W-1:0]                     cpu_data,
    input  logic                                  cpu_wr,
    output logic [REG_COUNT-1:0][DATA_W-1:0]      regs_o,
    output logic                                  mbit_o
);

    cpu_region_e                       region;
    logic                              sel_wr;
    logic                              bank_wr;
    logic [REG_IDX_W-1:0]              sel_q;
    logic [REG_COUNT-1:0][DATA_W-1:0]  regs_q;
    logic                              mbit_q;

    always_comb begin
        region  = decode_region(cpu_nib);
        sel_wr  = 1'b0;
        bank_wr = 1'b0;
        if (cpu_wr) begin
            unique case (region)
                RGN_SELECT: sel_wr  = 1'b1;
                RGN_BANK:   bank_wr = 1'b1;
                RGN_WRAM,
                RGN_OTHER:  ;
                default:    ;
            endcase
        end
    end

    // Index latch
    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (sel_wr)
            sel_q <= {cpu_data[DATA_W-1], cpu_data[0]};
    end

    // Banking registers
    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (bank_wr) begin
            for (int r = 0; r < REG_COUNT; r++) begin
                if (sel_q == REG_IDX_W'(r))
                    regs_q[r] <= cpu_data;
            end
        end
    end

    // Mirroring bit
    always_ff @(posedge clk) begin
        if (rst) begin
            mbit_q <= 1'b0;
        end else if (bank_wr) begin
            unique case (sel_q)
                REG_IDX_W'(IDX_CHR),
                REG_IDX_W'(IDX_INNER): mbit_q <= cpu_data[4];
                REG_IDX_W'(IDX_MODE):  mbit_q <= cpu_data[0];
                default:               mbit_q <= mbit_q;
            endcase
        end
    end

    assign regs_o = regs_q;
    assign mbit_o = mbit_q;

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_nib == 4'h5) |=> (sel_q == $past({cpu_data[DATA_W-1], cpu_data[0]})))
        else $error("index latch mismatch"); // R1

    AST_REG_STORE: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_nib[3]) |=> (regs_q[$past(sel_q)] == $past(cpu_data)))
        else $error("banking register not stored"); // R2

    AST_NONBANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !cpu_nib[3]) |=> $stable(regs_q))
        else $error("register changed outside banking range"); // R2

    AST_MBIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_nib[3] && sel_q == REG_IDX_W'(IDX_OUTER)) |=> $stable(mbit_q))
        else $error("mirroring bit moved on outer write"); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cpu_wr) |=> ($stable(regs_q) && $stable(sel_q) && $stable(mbit_q)))
        else $error("state changed without write"); // R13

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (regs_q == '0 && sel_q == '0 && !mbit_q))
        else $error("reset did not clear state"); // R11

endmodule

// File: rtl/mcm_prg_map.sv
module mcm_prg_map #(
    parameter int OUTER_W = 8,
    parameter int INNER_W = 4,
    parameter int OFS_W   = 14,
    localparam int PAGE_W = OUTER_W + 1
) (
    input  logic [OUTER_W-1:0]      outer,
    input  logic [INNER_W-1:0]      inner,
    input  logic                    slot,
    input  logic                    half_mode,
    input  logic [1:0]              game_size,
    input  logic [OFS_W:0]          cpu_low,
    output logic [PAGE_W+OFS_W-1:0] prg_addr
);

    logic [PAGE_W-1:0] imask;
    logic [PAGE_W-1:0] omask;
    logic [PAGE_W-1:0] base;
    logic [PAGE_W-1:0] inner_pg;
    logic [PAGE_W-1:0] dbl_pg;
    logic [PAGE_W-1:0] page [2];
    logic [PAGE_W-1:0] cur_page;

    always_comb begin
        for (int k = 0; k < PAGE_W; k++)
            imask[k] = (k <= int'(game_size));
        omask    = ~imask;
        base     = {outer, 1'b0};
        inner_pg = PAGE_W'(inner);
        dbl_pg   = {inner_pg[PAGE_W-2:0], 1'b0};
    end

    for (genvar gi = 0; gi < 2; gi++) begin : g_slot
        localparam logic [PAGE_W-1:0] HALF = PAGE_W'(gi);
        always_comb begin
            if (!half_mode)
                page[gi] = (base & omask) | ((dbl_pg | HALF) & imask);
            else if (slot != HALF[0])
                page[gi] = (base & omask) | (inner_pg & imask);
            else
                page[gi] = {base[PAGE_W-1:1], HALF[0]};
        end
    end

    always_comb begin
        cur_page = cpu_low[OFS_W] ? page[1] : page[0];
        prg_addr = {cur_page, cpu_low[OFS_W-1:0]};
    end

    always_comb begin
        if (!half_mode) begin
            AST_PAIR_32K: assert (page[1] == (page[0] | PAGE_W'(1)))
                else $error("32K pages not an even/odd pair"); // R7
        end
    end

    always_comb begin
        if (half_mode && !slot) begin
            AST_FIXED_LO: assert (page[0] == {outer, 1'b0})
                else $error("fixed lower page wrong"); // R8
        end
        if (half_mode && slot) begin
            AST_FIXED_HI: assert (page[1] == {outer, 1'b1})
                else $error("fixed upper page wrong"); // R9
        end
    end

endmodule

// File: rtl/mcm_ppu_map.sv
module mcm_ppu_map
    import mcm_pkg::*;
#(
    parameter int CHR_BANK_W = 2,
    parameter int CHR_OFS_W  = 13,
    localparam int CHR_AW    = CHR_BANK_W + CHR_OFS_W
) (
    input  logic [CHR_BANK_W-1:0] chr_bank,
    input  logic [1:0]            nt_sel,
    input  logic                  mbit,
    input  logic [CHR_OFS_W-1:0]  ppu_low,
    output logic [CHR_AW-1:0]     chr_addr,
    output logic                  nt_a10
);

    nt_mode_e mode;

    always_comb begin
        chr_addr = {chr_bank, ppu_low};
        mode     = nt_mode_e'(nt_sel);
        unique case (mode)
            NT_ONE_LO,
            NT_ONE_HI:     nt_a10 = mbit;
            NT_VERTICAL:   nt_a10 = ppu_low[10];
            NT_HORIZONTAL: nt_a10 = ppu_low[11];
            default:       nt_a10 = mbit;
        endcase
    end

endmodule

// File: rtl/mcart_mapper.sv
module mcart_mapper
    import mcm_pkg::*;
#(
    parameter int OUTER_W    = 8,
    parameter int INNER_W    = 4,
    parameter int CHR_BANK_W = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [15:0]                cpu_addr,
    input  logic [DATA_W-1:0]          cpu_data,
    input  logic                       cpu_wr,
    input  logic [13:0]                ppu_addr,
    output logic [OUTER_W+14:0]        prg_addr,
    output logic [CHR_BANK_W+12:0]     chr_addr,
    output logic                       wram_en,
    output logic                       nt_a10
);

    localparam int PRG_OFS_W = 14;
    localparam int CHR_OFS_W = 13;

    logic [REG_COUNT-1:0][DATA_W-1:0] regs;
    logic                             mbit;
    logic [DATA_W-1:0]                mode_r;
    logic [DATA_W-1:0]                outer_r;
    logic                             unused_bits;

    mcm_regfile i_regs (
        .clk      (clk),
        .rst      (rst),
        .cpu_nib  (cpu_addr[15:12]),
        .cpu_data (cpu_data),
        .cpu_wr   (cpu_wr),
        .regs_o   (regs),
        .mbit_o   (mbit)
    );

    assign mode_r  = regs[IDX_MODE];
    assign outer_r = regs[IDX_OUTER];

    mcm_prg_map #(
        .OUTER_W (OUTER_W),
        .INNER_W (INNER_W),
        .OFS_W   (PRG_OFS_W)
    ) i_prg (
        .outer     (outer_r[OUTER_W-1:0]),
        .inner     (regs[IDX_INNER][INNER_W-1:0]),
        .slot      (mode_r[MODE_SLOT_BIT]),
        .half_mode (mode_r[MODE_HALF_BIT]),
        .game_size (mode_r[MODE_GS_LSB+:2]),
        .cpu_low   (cpu_addr[PRG_OFS_W:0]),
        .prg_addr  (prg_addr)
    );

    mcm_ppu_map #(
        .CHR_BANK_W (CHR_BANK_W),
        .CHR_OFS_W  (CHR_OFS_W)
    ) i_ppu (
        .chr_bank (regs[IDX_CHR][CHR_BANK_W-1:0]),
        .nt_sel   (mode_r[MODE_NT_LSB+:2]),
        .mbit     (mbit),
        .ppu_low  (ppu_addr[CHR_OFS_W-1:0]),
        .chr_addr (chr_addr),
        .nt_a10   (nt_a10)
    );

    assign wram_en = (decode_region(cpu_addr[15:12]) == RGN_WRAM);

    assign unused_bits = ^{regs[IDX_CHR][DATA_W-1:CHR_BANK_W],
                           regs[IDX_INNER][DATA_W-1:INNER_W],
                           mode_r[DATA_W-1:6], ppu_addr[13]};

    always_comb begin
        AST_WRAM_WINDOW: assert (wram_en == (cpu_addr >= 16'h6000 && cpu_addr <= 16'h7FFF))
            else $error("work RAM window decode wrong"); // R12
    end

endmodule

// File: tb/test_mcart_mapper.sv
`timescale 1ns/1ps
module test_mcart_mapper;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_data;
    logic        cpu_wr;
    logic [13:0] ppu_addr;
    logic [22:0] prg_addr;
    logic [14:0] chr_addr;
    logic        wram_en;
    logic        nt_a10;

    always #2 clk = ~clk;

    mcart_mapper i_mcart_mapper (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
        .chr_addr(chr_addr), .wram_en(wram_en), .nt_a10(nt_a10)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 0;

    logic [1:0] m_sel;
    logic [7:0] m_reg [4];
    logic       m_mb;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [22:0] exp_prg(input logic [15:0] a);
        logic [1:0] gs;
        logic [8:0] im, om, base, inn, pg;
        logic       hi;
        gs   = m_reg[2][5:4];
        im   = 9'((2 << gs) - 1);
        om   = ~im;
        base = {m_reg[3], 1'b0};
        inn  = {5'b0, m_reg[1][3:0]};
        hi   = a[14];
        if (!m_reg[2][3])
            pg = (base & om) | (({inn[7:0], 1'b0} | {8'b0, hi}) & im);
        else if (hi != m_reg[2][2])
            pg = (base & om) | (inn & im);
        else
            pg = (base & 9'h1FE) | {8'b0, hi};
        return {pg, a[13:0]};
    endfunction

    function automatic logic exp_nt(input logic [13:0] p);
        case (m_reg[2][1:0])
            2'd2:    return p[10];
            2'd3:    return p[11];
            default: return m_mb;
        endcase
    endfunction

    task automatic do_reset();
        cpu_wr = 0; cpu_addr = 16'h0000; cpu_data = 8'h00; ppu_addr = '0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        m_sel = 0; m_mb = 0;
        for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1;
        @(negedge clk);
        cpu_wr = 0;
        if (a[15]) begin
            if (m_sel <= 2'd1) m_mb = d[4];
            else if (m_sel == 2'd2) m_mb = d[0];
            m_reg[m_sel] = d;
        end else if (a[15:12] == 4'h5) begin
            m_sel = {d[7], d[0]};
        end
    endtask

    task automatic set_reg(input logic [1:0] r, input logic [7:0] d);
        wr(16'h5000, {r[1], 6'b0, r[0]});
        wr(16'h8000, d);
    endtask

    task automatic probe(input string req, input logic [15:0] a, input logic [13:0] p);
        cpu_addr = a; ppu_addr = p;
        #1;
        chk(req, 32'(prg_addr), 32'(exp_prg(a)));
        chk("R3", 32'(chr_addr), 32'({m_reg[0][1:0], p[12:0]}));
        chk("R5", 32'(nt_a10), 32'(exp_nt(p)));
        chk("R12", 32'(wram_en), 32'(a >= 16'h6000 && a <= 16'h7FFF));
    endtask

    task automatic page_chk(input string req, input logic [15:0] a, input logic [8:0] pg);
        cpu_addr = a;
        #1;
        chk(req, 32'(prg_addr[22:14]), 32'(pg));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        do_reset();

        // R11 reset mapping
        @(negedge clk);
        page_chk("R11", 16'h8000, 9'd0);
        page_chk("R11", 16'hC000, 9'd1);
        ppu_addr = 14'h3C00; #1;
        chk("R11", 32'(nt_a10), 32'd0);

        // R1 index encoding (0x81 -> reg3, stray bits ignored)
        wr(16'h5ABC, 8'h81);
        wr(16'hF123, 8'h80);
        page_chk("R1", 16'h8000, 9'h100);
        wr(16'h5000, 8'h7E);           // index 0 despite bits 6:1
        wr(16'h8000, 8'h03);
        ppu_addr = 14'h0155; #1;
        chk("R1", 32'(chr_addr), 32'({2'd3, 13'h0155}));
        set_reg(2'd3, 8'h00);

        // R7 game size 3, inner 6 -> pages 12/13
        set_reg(2'd2, 8'h30);
        set_reg(2'd1, 8'h06);
        page_chk("R7", 16'h8000, 9'd12);
        page_chk("R7", 16'hC000, 9'd13);
        page_chk("R10", 16'hBFFF, 9'd12);

        // R8 slot 0, outer 8, inner 5 -> fixed 16, variable 21
        set_reg(2'd2, 8'h38);
        set_reg(2'd3, 8'h08);
        set_reg(2'd1, 8'h05);
        page_chk("R8", 16'h8000, 9'd16);
        page_chk("R8", 16'hC000, 9'd21);

        // R9 slot 1, outer 0, inner 7 -> variable 7, fixed 1
        set_reg(2'd2, 8'h3C);
        set_reg(2'd3, 8'h00);
        set_reg(2'd1, 8'h07);
        page_chk("R9", 16'h8000, 9'd7);
        page_chk("R9", 16'hC000, 9'd1);

        // R6 game size 0 keeps only inner bit 0 in 16K mode
        set_reg(2'd2, 8'h08);
        set_reg(2'd3, 8'h05);
        set_reg(2'd1, 8'h0F);
        page_chk("R6", 16'hC000, 9'h00B);

        // R4 / R5 mirroring bit rules
        set_reg(2'd2, 8'h00);
        ppu_addr = 14'h0C00; #1;
        chk("R5", 32'(nt_a10), 32'd0);
        set_reg(2'd0, 8'h10);
        #1 chk("R4", 32'(nt_a10), 32'd1);
        set_reg(2'd3, 8'h00);
        #1 chk("R4", 32'(nt_a10), 32'd1);
        set_reg(2'd1, 8'h00);
        #1 chk("R4", 32'(nt_a10), 32'd0);
        set_reg(2'd2, 8'h01);
        #1 chk("R4", 32'(nt_a10), 32'd1);
        set_reg(2'd2, 8'h02);
        ppu_addr = 14'h0400; #1;
        chk("R5", 32'(nt_a10), 32'd1);
        set_reg(2'd2, 8'h03);
        #1 chk("R5", 32'(nt_a10), 32'd0);
        ppu_addr = 14'h0800; #1;
        chk("R5", 32'(nt_a10), 32'd1);

        // R13 idle cycles on banking address
        @(negedge clk);
        cpu_addr = 16'h8000; cpu_data = 8'hFF; cpu_wr = 0;
        repeat (3) @(negedge clk);
        probe("R13", 16'h8000, 14'h0800);
        // R2 stray writes outside banking range
        wr(16'h6000, 8'hFF);
        wr(16'h4020, 8'hFF);
        probe("R2", 16'hC000, 14'h1234);

        // Random mix
        for (int it = 0; it < 600; it++) begin
            int op;
            op = $urandom_range(0, 6);
            if (op <= 1)
                wr({4'h5, 12'($urandom)}, 8'($urandom));
            else if (op <= 4)
                wr({1'b1, 15'($urandom)}, 8'($urandom));
            else
                wr({1'b0, 15'($urandom)}, 8'($urandom));
            probe("R10", 16'($urandom), 14'($urandom));
            probe("R7", {1'b1, 15'($urandom)}, 14'($urandom));
        end

        // R11 reset after activity
        do_reset();
        @(negedge clk);
        page_chk("R11", 16'h8000, 9'd0);
        page_chk("R11", 16'hC000, 9'd1);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule